// File: doc/BRIEF.md
# SDRAM Data-Bus Latency Aligner

This block sits between the burst sequencer of an SDRAM-style memory and its data pins. The sequencer tells it, one clock at a time, whether the current column command cycle carries a read beat or a write beat. For reads, the block delays that indication by a programmable latency of two or three clocks. It then raises a data-valid flag and a per-lane output-buffer enable exactly when the read data sits on the bus. For writes, it turns each beat into a per-lane write strobe on the same cycle.

A per-lane mask input acts differently on the two directions. On a read, a high mask bit turns that lane's output buffer off (high impedance) for the beat it lines up with. On a write, a high mask bit suppresses that lane's strobe, so the stored byte stays as it was. A clock-enable input suspends the whole pipeline with one clock of latency on both entry and exit. A write arriving while read beats are still in flight discards them.

Top module: `sdq_align`

## Requirements
- R1: Out of reset, `rd_valid` is 0, `oe` is all zero and `wr_en` is all zero.
- R2: With `lat_sel` = 0 (latency 2), a read beat accepted at edge k makes `rd_valid` high for the cycle that follows edge k+1.
- R3: With `lat_sel` = 1 (latency 3), a read beat accepted at edge k makes `rd_valid` high for the cycle that follows edge k+2.
- R4: Read beats on consecutive edges give consecutive valid cycles, and once the last beat has left the pipeline `rd_valid` and every `oe` bit return to 0.
- R5: A mask bit high at edge k clears that lane's `oe` bit for the cycle that follows edge k+1, which is the beat of a latency-2 read issued at edge k; `oe` is never high while `rd_valid` is low.
- R6: `wr_en[l]` is high in a cycle exactly when `wr_beat` is high, `mask[l]` is low and the pipeline is running; bit l of mask and strobe belong to the same lane.
- R7: A write beat accepted at an edge empties the read pipeline, so `rd_valid` and `oe` are 0 after that edge; a read beat given with it is dropped.
- R8: `clk_en` low at edge k makes edge k+1 inactive. At that edge the read and mask pipelines hold, read and write beats presented for it are ignored, and `wr_en` stays 0 in the cycle before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en | input | 1 | Clock enable; low suspends the next edge |
| lat_sel | input | 1 | Read latency select: 0 = 2 clocks, 1 = 3 clocks |
| rd_beat | input | 1 | Read beat from the burst sequencer this cycle |
| wr_beat | input | 1 | Write beat from the burst sequencer this cycle |
| mask | input | LANES | Per-lane data mask |
| rd_valid | output | 1 | Read data is on the bus this cycle |
| oe | output | LANES | Per-lane output-buffer enable |
| wr_en | output | LANES | Per-lane write strobe to storage |

## Verification
The hardest situation to reach is a suspended edge that lands in the middle of a read burst while beats and a write are presented for that edge. The clock enable must drop exactly one cycle before the target edge, so that the stretched valid window and the ignored beats fall in known cycles. The stimulus issues one read, lowers the enable for one cycle and then offers both a read and a write for the frozen edge. It expects the valid window to last one extra cycle with no cancel and no strobe. A second sequence issues a write while three latency-3 beats are in flight, which checks the cancel path.

// File: rtl/sdq_pkg.sv
package sdq_pkg;
   typedef enum logic {
      LAT_TWO   = 1'b0,
      LAT_THREE = 1'b1
   } lat_e;

   localparam int MIN_LAT = 2;
   localparam int MAX_LAT = 3;
endpackage

// File: rtl/sdq_rd_pipe.sv
module sdq_rd_pipe #(
   parameter int DEPTH = sdq_pkg::MAX_LAT
) (
   input  logic clk,
   input  logic rst_n,
   input  logic adv,
   input  logic beat,
   input  logic kill,
   input  logic lat_sel,
   output logic valid
);
   import sdq_pkg::*;

   localparam int SHORT_TAP = DEPTH - 2;
   localparam int LONG_TAP  = DEPTH - 1;

   initial begin
      if (DEPTH < MIN_LAT) $error("sdq_rd_pipe: DEPTH below minimum latency");
   end

   logic [DEPTH-1:0] stage;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage <= '0;
      end else if (adv) begin
         if (kill) stage <= '0;
         else      stage <= {stage[DEPTH-2:0], beat};
      end
   end

   lat_e lat;
   assign lat   = lat_e'(lat_sel);
   assign valid = (lat == LAT_THREE) ? stage[LONG_TAP] : stage[SHORT_TAP];

   AST_PIPE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(stage)) else $error("read pipe moved while frozen"); // R8
endmodule

// File: rtl/sdq_mask_dly.sv
module sdq_mask_dly #(
   parameter int LANES = 2,
   parameter int DLY   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  logic [LANES-1:0] mask_in,
   output logic [LANES-1:0] mask_out
);
   initial begin
      if (DLY < 2)   $error("sdq_mask_dly: DLY must be at least 2");
      if (LANES < 1) $error("sdq_mask_dly: LANES must be at least 1");
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [DLY-1:0] sh;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   sh <= '0;
         else if (adv) sh <= {sh[DLY-2:0], mask_in[l]};
      end
      assign mask_out[l] = sh[DLY-1];
   end

   AST_MASK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(mask_out)) else $error("mask delay moved while frozen"); // R8
endmodule

// File: rtl/sdq_wr_gate.sv
module sdq_wr_gate #(
   parameter int LANES = 2
) (
   input  logic             run,
   input  logic             beat,
   input  logic [LANES-1:0] mask,
   output logic [LANES-1:0] strobe
);
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign strobe[l] = run & beat & ~mask[l];
   end
endmodule

// File: rtl/sdq_align.sv
module sdq_align #(
   parameter int LANES = 2,
   parameter int DEPTH = sdq_pkg::MAX_LAT
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clk_en,
   input  logic             lat_sel,
   input  logic             rd_beat,
   input  logic             wr_beat,
   input  logic [LANES-1:0] mask,
   output logic             rd_valid,
   output logic [LANES-1:0] oe,
   output logic [LANES-1:0] wr_en
);
   localparam int MASK_DLY = 2;

   initial begin
      if (LANES < 1) $error("sdq_align: LANES must be at least 1");
   end

   logic             ce_q;
   logic [LANES-1:0] mask_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ce_q <= 1'b1;
      else        ce_q <= clk_en;
   end

   sdq_rd_pipe #(.DEPTH(DEPTH)) u_pipe (
      .clk     (clk),
      .rst_n   (rst_n),
      .adv     (ce_q),
      .beat    (rd_beat & ~wr_beat),
      .kill    (wr_beat),
      .lat_sel (lat_sel),
      .valid   (rd_valid)
   );

   sdq_mask_dly #(.LANES(LANES), .DLY(MASK_DLY)) u_mask (
      .clk      (clk),
      .rst_n    (rst_n),
      .adv      (ce_q),
      .mask_in  (mask),
      .mask_out (mask_d)
   );

   sdq_wr_gate #(.LANES(LANES)) u_wr (
      .run    (ce_q),
      .beat   (wr_beat),
      .mask   (mask),
      .strobe (wr_en)
   );

   assign oe = {LANES{rd_valid}} & ~mask_d;

   AST_OE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      (|oe) |-> rd_valid) else $error("buffer enabled without valid data"); // R5
   AST_WR_CANCELS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_beat && ce_q) |=> (!rd_valid && oe == '0)) else $error("read survived write"); // R7
   AST_WR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(clk_en)) |-> wr_en == '0) else $error("strobe while frozen"); // R8
endmodule

// File: tb/sdq_align_test.sv
module sdq_align_test;
   localparam int L = 2;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         clk_en = 1'b1;
   logic         lat_sel = 1'b0;
   logic         rd_beat = 1'b0;
   logic         wr_beat = 1'b0;
   logic [L-1:0] mask = '0;
   logic         rd_valid;
   logic [L-1:0] oe;
   logic [L-1:0] wr_en;

   always #2.5 clk = ~clk;

   sdq_align #(.LANES(L)) uut (
      .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .lat_sel(lat_sel),
      .rd_beat(rd_beat), .wr_beat(wr_beat), .mask(mask),
      .rd_valid(rd_valid), .oe(oe), .wr_en(wr_en)
   );

   int n_checks = 0;
   int n_fails  = 0;
   int cyc      = 0;
   int wd       = 0;
   logic prev_ce = 1'b1;

   logic         exp_rv  [int];
   logic [L-1:0] exp_oe  [int];
   string        exp_tag [int];

   task automatic expect_at(input int c, input logic rv, input logic [L-1:0] o, input string tag);
      exp_rv[c]  = rv;
      exp_oe[c]  = o;
      exp_tag[c] = tag;
   endtask

   task automatic chk(input logic ok, input string tag, input string what,
                      input logic [7:0] act, input logic [7:0] expv);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s cycle %0d %s actual=%0h expected=%0h", tag, cyc, what, act, expv);
      end
   endtask

   task automatic step(input logic rd, input logic wr, input logic [L-1:0] m, input logic ce);
      logic [L-1:0] we_exp;
      @(negedge clk);
      if (exp_rv.exists(cyc)) begin
         chk(rd_valid == exp_rv[cyc], exp_tag[cyc], "rd_valid", 8'(rd_valid), 8'(exp_rv[cyc]));
         chk(oe == exp_oe[cyc], exp_tag[cyc], "oe", 8'(oe), 8'(exp_oe[cyc]));
      end else begin
         chk(rd_valid == 1'b0, "R4", "idle rd_valid", 8'(rd_valid), 8'd0);
         chk(oe == '0, "R4", "idle oe", 8'(oe), 8'd0);
      end
      rd_beat = rd;
      wr_beat = wr;
      mask    = m;
      clk_en  = ce;
      #1;
      we_exp = (wr && prev_ce) ? ~m : '0;
      chk(wr_en == we_exp, prev_ce ? "R6" : "R8", "wr_en", 8'(wr_en), 8'(we_exp));
      prev_ce = ce;
      cyc++;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(1'b0, 1'b0, '0, 1'b1);
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   endtask

   always @(posedge clk) begin
      wd++;
      if (wd > 20000) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      int b;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: state just out of reset
      expect_at(0, 1'b0, '0, "R1");
      expect_at(1, 1'b0, '0, "R1");
      idle(2);

      // R2: latency 2 single beat
      lat_sel = 1'b0;
      expect_at(cyc + 2, 1'b1, 2'b11, "R2");
      step(1'b1, 1'b0, '0, 1'b1);
      idle(4);

      // R3: latency 3 single beat
      lat_sel = 1'b1;
      expect_at(cyc + 2, 1'b0, '0, "R3");
      expect_at(cyc + 3, 1'b1, 2'b11, "R3");
      step(1'b1, 1'b0, '0, 1'b1);
      idle(5);

      // R4 / R5: back-to-back latency 2 beats with read mask
      lat_sel = 1'b0;
      b = cyc;
      expect_at(b + 2, 1'b1, 2'b11, "R4");
      expect_at(b + 3, 1'b1, 2'b10, "R5");
      expect_at(b + 4, 1'b1, 2'b11, "R4");
      expect_at(b + 5, 1'b1, 2'b00, "R5");
      expect_at(b + 6, 1'b0, 2'b00, "R4");
      step(1'b1, 1'b0, 2'b00, 1'b1);
      step(1'b1, 1'b0, 2'b01, 1'b1);
      step(1'b1, 1'b0, 2'b00, 1'b1);
      step(1'b1, 1'b0, 2'b11, 1'b1);
      idle(5);

      // R7: write cancels in-flight latency 3 reads, simultaneous read dropped
      lat_sel = 1'b1;
      b = cyc;
      expect_at(b + 3, 1'b1, 2'b11, "R7");
      expect_at(b + 4, 1'b0, 2'b00, "R7");
      expect_at(b + 5, 1'b0, 2'b00, "R7");
      expect_at(b + 6, 1'b0, 2'b00, "R7");
      step(1'b1, 1'b0, 2'b00, 1'b1);
      step(1'b1, 1'b0, 2'b00, 1'b1);
      step(1'b1, 1'b0, 2'b00, 1'b1);
      step(1'b1, 1'b1, 2'b00, 1'b1);
      idle(5);

      // R8: one suspended edge during a latency 2 read; beats for it ignored
      lat_sel = 1'b0;
      b = cyc;
      expect_at(b + 2, 1'b1, 2'b11, "R8");
      expect_at(b + 3, 1'b1, 2'b11, "R8");
      expect_at(b + 4, 1'b0, 2'b00, "R8");
      expect_at(b + 5, 1'b0, 2'b00, "R8");
      step(1'b1, 1'b0, 2'b00, 1'b1);
      step(1'b0, 1'b0, 2'b00, 1'b0);
      step(1'b1, 1'b1, 2'b00, 1'b1);
      idle(5);

      // R6: write strobes follow the per-lane mask in the same cycle
      step(1'b0, 1'b1, 2'b10, 1'b1);
      step(1'b0, 1'b1, 2'b00, 1'b1);
      step(1'b0, 1'b1, 2'b01, 1'b1);
      step(1'b0, 1'b0, 2'b00, 1'b1);
      idle(3);

      finish_run();
   end
endmodule